// File: doc/BRIEF.md
# Bridge Quiesce and Reset Sequencer

This block brings a clock-gated sub-unit into service and takes it back out. It owns four controls: a clock enable, an active-low reset line (driven here as a reset-release bit, high meaning the unit is out of reset), and a stop request for each of two asynchronous bus bridges, one on the master side and one on the slave side. Each bridge answers its stop request through an acknowledge input. A bridge is ungated by clearing its stop request and waiting for the acknowledge to fall. It is quiesced by setting the stop request and waiting for the acknowledge to rise.

Bring-up first runs the clock long enough for the reset to propagate. It then gates the clock, releases reset, restarts the clock, and ungates the master bridge before the slave bridge. Teardown quiesces the slave bridge, then the master bridge, then stops the clock and asserts reset. Every handshake is bounded by a cycle-count timeout of one microsecond. A handshake that times out rolls back the steps already taken and ends with an error code naming the failing bridge. A reset request runs a complete teardown followed by a complete bring-up. It is honoured only while the parent domain reports power.

A build without bridges skips both handshakes and sequences only the clock and the reset. The parent power switch, the clock generator and the bridge internals lie outside this block.

Top module: `gated_unit_sequencer`

## Requirements
- R1: After reset, clk_en=0, rst_rel=0, mst_stop=1, slv_stop=1, busy=0, done=0, err=0 and err_code=0.
- R2: On bring-up, clk_en stays high for exactly PROP cycles with rst_rel low, where PROP = max(MIN_PROP_CYC, CLK_MHZ). clk_en then drops for one cycle. rst_rel rises while clk_en is low, and clk_en returns one cycle later.
- R3: After reset release, mst_stop falls before slv_stop. A successful bring-up raises done PROP+3+2(L+1) cycles after the command, where L is the acknowledge delay in cycles.
- R4: A handshake succeeds when the acknowledge arrives within TMO = CLK_MHZ cycles of the request (L = TMO-1 passes) and fails otherwise (L = TMO fails).
- R5: If the master bridge fails to ungate during bring-up, clk_en falls and mst_stop is set again, and rst_rel falls one cycle later. done comes PROP+3+TMO+1 cycles after the command, with err=1 and err_code=1.
- R6: If the slave bridge fails to ungate, both stop requests are set and the master handshake is awaited. Only after that does clk_en fall, and then rst_rel falls. The result is err=1 with err_code=2.
- R7: Teardown sets slv_stop, then mst_stop, then clears clk_en, then clears rst_rel. done arrives 2(L+1)+2 cycles after the command. rst_rel is never low while either stop request is clear.
- R8: If the master bridge fails to quiesce during teardown, slv_stop is cleared again and clk_en and rst_rel are left high. The result is err=1 with err_code=1.
- R9: If the slave bridge fails to quiesce during teardown, slv_stop is cleared again and clk_en and rst_rel are left high. The result is err=1 with err_code=2.
- R10: With HAS_BRIDGES=0, both stop requests stay at 1 and the acknowledges are ignored. Bring-up takes PROP+3 cycles and teardown takes 2 cycles.
- R11: cmd_reset is accepted only when parent_up=1. It runs a teardown followed by a bring-up and raises a single done after 4(L+1)+PROP+4 cycles. With parent_up=0 it has no effect.
- R12: Commands that arrive while busy=1 are ignored. When several commands arrive together in idle, the priority is cmd_off, then cmd_on, then cmd_reset.
- R13: done is a one-cycle pulse, raised while busy=0. err holds until the next accepted command clears it. err_code encodes 0 for no error, 1 for the master bridge and 2 for the slave bridge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer |
| cmd_on | input | 1 | Bring-up command (single-cycle pulse) |
| cmd_off | input | 1 | Teardown command (single-cycle pulse) |
| cmd_reset | input | 1 | Teardown-then-bring-up command |
| parent_up | input | 1 | Parent domain powered |
| mst_ack | input | 1 | Master bridge acknowledge |
| slv_ack | input | 1 | Slave bridge acknowledge |
| clk_en | output | 1 | Sub-unit clock enable |
| rst_rel | output | 1 | Sub-unit reset release (reset line inverted) |
| mst_stop | output | 1 | Master bridge stop request |
| slv_stop | output | 1 | Slave bridge stop request |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Last sequence failed |
| err_code | output | 2 | 0 none, 1 master bridge, 2 slave bridge |

## Verification
Every result is registered, so each one is due a fixed number of cycles after the command edge. For bring-up that is PROP+3, plus L+1 for each bridge handshake, plus TMO for each timed-out handshake. For teardown it is 2 plus the same handshake terms. The bench drives commands and samples outputs on falling edges and counts falling edges until done, then compares that count with the closed-form latency for each case. A bridge model with a programmable delay is swept over several delays, including the values on either side of the timeout. The order checks compare the cycle stamps at which each control toggled.

// File: rtl/gated_unit_sequencer.sv
`timescale 1ns/1ps
module gated_unit_sequencer #(
  parameter int CLK_MHZ      = 200,
  parameter int MIN_PROP_CYC = 32,
  parameter bit HAS_BRIDGES  = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_on,
  input  logic       cmd_off,
  input  logic       cmd_reset,
  input  logic       parent_up,
  input  logic       mst_ack,
  input  logic       slv_ack,
  output logic       clk_en,
  output logic       rst_rel,
  output logic       mst_stop,
  output logic       slv_stop,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic [1:0] err_code
);

  localparam int TMO_CYC  = (CLK_MHZ < 1) ? 1 : CLK_MHZ;
  localparam int PROP_CYC = (TMO_CYC > MIN_PROP_CYC) ? TMO_CYC : MIN_PROP_CYC;
  localparam int CNT_MAX  = (PROP_CYC > TMO_CYC) ? PROP_CYC : TMO_CYC;
  localparam int CW       = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] TMO_LAST  = CW'(TMO_CYC - 1);
  localparam logic [CW-1:0] PROP_LAST = CW'(PROP_CYC - 1);
  localparam logic [1:0] EC_NONE = 2'd0;
  localparam logic [1:0] EC_MST  = 2'd1;
  localparam logic [1:0] EC_SLV  = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_PROP, S_GATE, S_REL,
    S_MUNG, S_SUNG, S_RBMQ, S_RBRST,
    S_OSQ,  S_OMQ,  S_ORESLV, S_ORST
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          rseq;
  logic          ce_q, rr_q, ms_q, ss_q, done_q, err_q;
  logic [1:0]    ec_q;

  wire tmo_hit  = (cnt == TMO_LAST);
  wire prop_end = (cnt == PROP_LAST);

  assign clk_en   = ce_q;
  assign rst_rel  = rr_q;
  assign mst_stop = ms_q;
  assign slv_stop = ss_q;
  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign err      = err_q;
  assign err_code = ec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      rseq   <= 1'b0;
      ce_q   <= 1'b0;
      rr_q   <= 1'b0;
      ms_q   <= 1'b1;
      ss_q   <= 1'b1;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      ec_q   <= EC_NONE;
    end else begin
      done_q <= 1'b0;
      cnt    <= cnt + 1'b1;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (cmd_off || (cmd_reset && parent_up && !cmd_on)) begin
            err_q <= 1'b0;
            ec_q  <= EC_NONE;
            rseq  <= !cmd_off;
            if (HAS_BRIDGES) begin
              ss_q <= 1'b1;
              st   <= S_OSQ;
            end else begin
              ce_q <= 1'b0;
              st   <= S_ORST;
            end
          end else if (cmd_on) begin
            err_q <= 1'b0;
            ec_q  <= EC_NONE;
            rseq  <= 1'b0;
            ce_q  <= 1'b1;
            st    <= S_PROP;
          end
        end
        S_PROP: begin
          if (prop_end) begin
            ce_q <= 1'b0;
            cnt  <= '0;
            st   <= S_GATE;
          end
        end
        S_GATE: begin
          rr_q <= 1'b1;
          cnt  <= '0;
          st   <= S_REL;
        end
        S_REL: begin
          ce_q <= 1'b1;
          cnt  <= '0;
          if (HAS_BRIDGES) begin
            ms_q <= 1'b0;
            st   <= S_MUNG;
          end else begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
        S_MUNG: begin
          if (!mst_ack) begin
            ss_q <= 1'b0;
            cnt  <= '0;
            st   <= S_SUNG;
          end else if (tmo_hit) begin
            ce_q <= 1'b0;
            ms_q <= 1'b1;
            ec_q <= EC_MST;
            cnt  <= '0;
            st   <= S_RBRST;
          end
        end
        S_SUNG: begin
          if (!slv_ack) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else if (tmo_hit) begin
            ss_q <= 1'b1;
            ms_q <= 1'b1;
            ec_q <= EC_SLV;
            cnt  <= '0;
            st   <= S_RBMQ;
          end
        end
        S_RBMQ: begin
          if (mst_ack || tmo_hit) begin
            ce_q <= 1'b0;
            cnt  <= '0;
            st   <= S_RBRST;
          end
        end
        S_RBRST: begin
          rr_q   <= 1'b0;
          err_q  <= 1'b1;
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        S_OSQ: begin
          if (slv_ack) begin
            ms_q <= 1'b1;
            cnt  <= '0;
            st   <= S_OMQ;
          end else if (tmo_hit) begin
            ss_q   <= 1'b0;
            ec_q   <= EC_SLV;
            err_q  <= 1'b1;
            done_q <= 1'b1;
            rseq   <= 1'b0;
            st     <= S_IDLE;
          end
        end
        S_OMQ: begin
          if (mst_ack) begin
            ce_q <= 1'b0;
            cnt  <= '0;
            st   <= S_ORST;
          end else if (tmo_hit) begin
            ss_q <= 1'b0;
            ec_q <= EC_MST;
            cnt  <= '0;
            st   <= S_ORESLV;
          end
        end
        S_ORESLV: begin
          if (!slv_ack || tmo_hit) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
            rseq   <= 1'b0;
            st     <= S_IDLE;
          end
        end
        S_ORST: begin
          rr_q <= 1'b0;
          cnt  <= '0;
          if (rseq) begin
            rseq <= 1'b0;
            ce_q <= 1'b1;
            st   <= S_PROP;
          end else begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/gus_checker.sv
`timescale 1ns/1ps
module gus_checker #(
  parameter int TMO  = 200,
  parameter int PROP = 200
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_on,
  input logic       cmd_off,
  input logic       cmd_reset,
  input logic       parent_up,
  input logic       mst_ack,
  input logic       slv_ack,
  input logic       clk_en,
  input logic       rst_rel,
  input logic       mst_stop,
  input logic       slv_stop,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [1:0] err_code
);

  int pend;
  int cerun;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= 0;
      cerun <= 0;
    end else begin
      pend  <= (busy && ((mst_stop != mst_ack) || (slv_stop != slv_ack))) ? pend + 1 : 0;
      cerun <= clk_en ? ((cerun < PROP + 4) ? cerun + 1 : cerun) : 0;
    end
  end

  // R2
  rel_clk_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_rel) |-> !clk_en);

  // R2
  prop_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(clk_en) && !rst_rel) |-> (cerun >= PROP));

  // R3
  mst_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mst_stop) |-> slv_stop);

  // R7
  reset_quiesced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_rel |-> (mst_stop && slv_stop));

  // R4
  hs_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= 6 * TMO + 16);

  // R12
  start_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_on || cmd_off || (cmd_reset && parent_up)));

  // R13
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R13
  err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (err_code != 2'd0));

endmodule

bind gated_unit_sequencer gus_checker #(.TMO(TMO_CYC), .PROP(PROP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .cmd_off(cmd_off),
  .cmd_reset(cmd_reset), .parent_up(parent_up), .mst_ack(mst_ack),
  .slv_ack(slv_ack), .clk_en(clk_en), .rst_rel(rst_rel),
  .mst_stop(mst_stop), .slv_stop(slv_stop), .busy(busy), .done(done),
  .err(err), .err_code(err_code)
);

// File: tb/tb_gated_unit_sequencer.sv
`timescale 1ns/1ps
module tb_gated_unit_sequencer;
  localparam int MHZ  = 10;
  localparam int TMO  = 10;
  localparam int PROP = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic cmd_on = 1'b0, cmd_off = 1'b0, cmd_reset = 1'b0, parent_up = 1'b1;
  logic mack, sack;
  logic ce, rr, ms, ss, bsy, dn, er;
  logic [1:0] ec;
  logic nb_ce, nb_rr, nb_ms, nb_ss, nb_bsy, nb_dn, nb_er;
  logic [1:0] nb_ec;

  int lat = 0;
  logic stk_m_en = 1'b0, stk_m_v = 1'b0, stk_s_en = 1'b0, stk_s_v = 1'b0;
  logic [15:0] hm, hs;

  gated_unit_sequencer #(.CLK_MHZ(MHZ), .MIN_PROP_CYC(32), .HAS_BRIDGES(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .cmd_off(cmd_off),
    .cmd_reset(cmd_reset), .parent_up(parent_up), .mst_ack(mack), .slv_ack(sack),
    .clk_en(ce), .rst_rel(rr), .mst_stop(ms), .slv_stop(ss), .busy(bsy),
    .done(dn), .err(er), .err_code(ec));

  gated_unit_sequencer #(.CLK_MHZ(MHZ), .MIN_PROP_CYC(32), .HAS_BRIDGES(1'b0)) dut_nb (
    .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .cmd_off(cmd_off),
    .cmd_reset(cmd_reset), .parent_up(parent_up), .mst_ack(1'b1), .slv_ack(1'b1),
    .clk_en(nb_ce), .rst_rel(nb_rr), .mst_stop(nb_ms), .slv_stop(nb_ss), .busy(nb_bsy),
    .done(nb_dn), .err(nb_er), .err_code(nb_ec));

  always @(posedge clk) begin
    if (!rst_n) begin
      hm <= '1;
      hs <= '1;
    end else begin
      hm <= {hm[14:0], ms};
      hs <= {hs[14:0], ss};
    end
  end

  always_comb begin
    mack = stk_m_en ? stk_m_v : ((lat == 0) ? ms : hm[lat-1]);
    sack = stk_s_en ? stk_s_v : ((lat == 0) ? ss : hs[lat-1]);
  end

  int gcyc = 0, run = 0, last_run = 0;
  int t_ce_fall = 0, t_rr_rise = 0, t_rr_fall = 0;
  int t_ms_fall = 0, t_ms_rise = 0, t_ss_fall = 0, t_ss_rise = 0;
  logic ce_at_rise = 1'b0;
  logic p_ce = 1'b0, p_rr = 1'b0, p_ms = 1'b1, p_ss = 1'b1;

  always @(negedge clk) begin
    gcyc++;
    if (p_ce && !ce) begin t_ce_fall = gcyc; last_run = run; end
    run = ce ? run + 1 : 0;
    if (rr && !p_rr) begin t_rr_rise = gcyc; ce_at_rise = ce; end
    if (!rr && p_rr) t_rr_fall = gcyc;
    if (!ms && p_ms) t_ms_fall = gcyc;
    if (ms && !p_ms) t_ms_rise = gcyc;
    if (!ss && p_ss) t_ss_fall = gcyc;
    if (ss && !p_ss) t_ss_rise = gcyc;
    p_ce = ce; p_rr = rr; p_ms = ms; p_ss = ss;
  end

  int nchk = 0, nfail = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  int r_lat, r_err1, r_dw, r_start;

  task automatic run_cmd(input int kind, input bit nb, input int inj);
    int cyc;
    bit got;
    @(negedge clk);
    case (kind)
      0: cmd_on = 1'b1;
      1: cmd_off = 1'b1;
      default: cmd_reset = 1'b1;
    endcase
    r_start = gcyc;
    cyc = 0;
    got = 1'b0;
    r_err1 = 0;
    while (!got && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      cmd_on = 1'b0; cmd_off = 1'b0; cmd_reset = 1'b0;
      if (cyc == inj) cmd_off = 1'b1;
      if (cyc == 1) r_err1 = int'(nb ? nb_er : er);
      if (nb ? nb_dn : dn) got = 1'b1;
    end
    r_lat = got ? cyc : -1;
    @(negedge clk);
    cmd_off = 1'b0;
    r_dw = int'(nb ? nb_dn : dn);
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
    while (bsy || nb_bsy) @(negedge clk);
  endtask

  task automatic state_is(input string tag, input int ce_e, input int rr_e, input int ms_e, input int ss_e);
    chk(tag, "clk_en", int'(ce), ce_e);
    chk(tag, "rst_rel", int'(rr), rr_e);
    chk(tag, "mst_stop", int'(ms), ms_e);
    chk(tag, "slv_stop", int'(ss), ss_e);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    state_is("R1", 0, 0, 1, 1);
    chk("R1", "busy", int'(bsy), 0);
    chk("R1", "done", int'(dn), 0);
    chk("R1", "err", int'(er), 0);
    chk("R1", "err_code", int'(ec), 0);
    chk("R1", "nb clk_en", int'(nb_ce), 0);

    // R10 no-bridge build
    run_cmd(0, 1'b1, -1);
    chk("R10", "nb on latency", r_lat, PROP + 3);
    chk("R10", "nb clk_en", int'(nb_ce), 1);
    chk("R10", "nb rst_rel", int'(nb_rr), 1);
    chk("R10", "nb stops", int'(nb_ms & nb_ss), 1);
    settle();
    run_cmd(1, 1'b1, -1);
    chk("R10", "nb off latency", r_lat, 2);
    chk("R10", "nb clk_en", int'(nb_ce), 0);
    chk("R10", "nb rst_rel", int'(nb_rr), 0);
    settle();

    // R2 R3 R7 delay sweep, including R4 pass side at TMO-1
    foreach (lat_set[i]) begin
      lat = lat_set[i];
      settle();
      run_cmd(0, 1'b0, -1);
      chk("R3", $sformatf("on latency L=%0d", lat), r_lat, PROP + 3 + 2 * (lat + 1));
      chk("R2", "clock pulse length", last_run, PROP);
      chk("R2", "clock low at release", int'(ce_at_rise), 0);
      chk("R3", "release before master", int'(t_rr_rise < t_ms_fall), 1);
      chk("R3", "master before slave", int'(t_ms_fall < t_ss_fall), 1);
      chk("R13", "done width", r_dw, 0);
      state_is("R4", 1, 1, 0, 0);
      chk("R4", "err", int'(er), 0);
      settle();
      run_cmd(1, 1'b0, -1);
      chk("R7", $sformatf("off latency L=%0d", lat), r_lat, 2 * (lat + 1) + 2);
      chk("R7", "slave before master", int'(t_ss_rise < t_ms_rise), 1);
      chk("R7", "master before clock", int'(t_ms_rise < t_ce_fall), 1);
      chk("R7", "clock before reset", int'(t_ce_fall < t_rr_fall), 1);
      state_is("R7", 0, 0, 1, 1);
    end

    // R4 R5 acknowledge one cycle too late
    lat = TMO;
    settle();
    run_cmd(0, 1'b0, -1);
    chk("R5", "master fail latency", r_lat, PROP + 3 + TMO + 1);
    chk("R5", "err", int'(er), 1);
    chk("R5", "err_code", int'(ec), 1);
    state_is("R5", 0, 0, 1, 1);

    // R6 slave stuck
    lat = 1;
    stk_s_en = 1'b1; stk_s_v = 1'b1;
    settle();
    run_cmd(0, 1'b0, -1);
    chk("R13", "err cleared on accept", r_err1, 0);
    chk("R6", "slave fail latency", r_lat, PROP + 3 + 2 + TMO + 2 + 1);
    chk("R6", "err_code", int'(ec), 2);
    chk("R6", "master requiesced before clock off", int'(t_ms_rise < t_ce_fall), 1);
    state_is("R6", 0, 0, 1, 1);
    stk_s_en = 1'b0;

    settle();
    run_cmd(0, 1'b0, -1);
    chk("R13", "err after good on", int'(er), 0);

    // R9 slave fails to quiesce
    stk_s_en = 1'b1; stk_s_v = 1'b0;
    settle();
    run_cmd(1, 1'b0, -1);
    chk("R9", "latency", r_lat, TMO + 1);
    chk("R9", "err_code", int'(ec), 2);
    state_is("R9", 1, 1, 0, 0);
    stk_s_en = 1'b0;

    // R8 master fails to quiesce
    stk_m_en = 1'b1; stk_m_v = 1'b0;
    settle();
    run_cmd(1, 1'b0, -1);
    chk("R8", "latency", r_lat, 2 + TMO + 2 + 1);
    chk("R8", "err_code", int'(ec), 1);
    state_is("R8", 1, 1, 1, 0);
    stk_m_en = 1'b0;
    settle();
    run_cmd(1, 1'b0, -1);
    state_is("R8", 0, 0, 1, 1);

    // R12 command during busy ignored
    settle();
    run_cmd(0, 1'b0, 5);
    chk("R12", "latency with stray off", r_lat, PROP + 3 + 4);
    state_is("R12", 1, 1, 0, 0);

    // R11 reset ignored with parent down
    settle();
    parent_up = 1'b0;
    @(negedge clk);
    cmd_reset = 1'b1;
    @(negedge clk);
    cmd_reset = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (bsy) seen = 1;
      end
      chk("R11", "busy with parent down", seen, 0);
    end
    state_is("R11", 1, 1, 0, 0);
    parent_up = 1'b1;
    settle();
    run_cmd(2, 1'b0, -1);
    chk("R11", "reset latency", r_lat, 4 * 2 + PROP + 4);
    chk("R11", "reset asserted during request", int'(t_rr_fall > r_start), 1);
    chk("R11", "err", int'(er), 0);
    state_is("R11", 1, 1, 0, 0);

    settle();
    summary();
    $finish;
  end

  int lat_set[4] = '{0, 1, 4, 9};

endmodule